// File: doc/BRIEF.md
# Complementary PWM Generator with Dead Time

This block generates a pulse-width-modulated waveform and delivers it as a complementary pair: a true drive and an inverted drive. Between any change of one drive and the rise of the other, both drives are held low for a programmable number of counting ticks. The counting clock comes from a power-of-two prescaler in front of the period counter. The duty word has two parts. A coarse part sets the high time in whole counts. A fine part stretches the high time by one count in a chosen number of every four consecutive periods, so the average duty has a quarter-count resolution.

Software sets the period, the duty word, the prescaler code, the dead-time length and an enable. Period and duty are captured into working copies only when a period starts, so a write made mid-period never produces a runt pulse. A one-clock marker shows the start of every period.

Top module: `cpwm_dt`

## Requirements
- R1: Prescaler code s (3 bits) gives one counting tick every 2^s clocks for s = 0..6, and code 7 behaves as code 6 (divide by 64). A period therefore lasts len * div clocks.
- R2: A period lasts len ticks, where len is the period value; a period value of 0 behaves as 1.
- R3: Without dead time, the raw high time of a period is the coarse duty (duty bits 9:2) in ticks, starting at count zero of the period.
- R4: The fine duty (bits 1:0) adds one tick of high time in frames 0..fine-1 of a repeating four-period frame sequence, so four consecutive periods hold 4*coarse + fine high ticks.
- R5: A duty word of zero keeps the true drive low. A coarse duty at or above len keeps the true drive high and the inverted drive low.
- R6: The two drives are never high together. Each drive rises only after the raw waveform has held its new level for dt ticks (dt 4 bits), so every pulse is shortened by dt ticks, or removed when it is no longer than dt ticks.
- R7: New period and duty values take effect only at the start of the next period; the current period finishes with the old values.
- R8: While enable is low, both drives and the period marker are low and the counters are cleared. After enable rises, the first period starts from count zero and ends len * div clocks after the first clock edge that sees enable high.
- R9: The period marker is high for the first clock of each new period after the first.
- R10: After reset, both drives and the period marker are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low clears the generator |
| period_i | input | 8 | Period length in ticks |
| duty_i | input | 10 | Duty word: coarse in bits 9:2, fine in bits 1:0 |
| psc_sel_i | input | 3 | Prescaler code |
| dead_i | input | 4 | Dead time in ticks |
| out_p | output | 1 | True drive |
| out_n | output | 1 | Inverted drive |
| period_end | output | 1 | One-clock marker at each period start |

## Verification
The hardest state to reach is a steady dithered sequence. There, every frame of the four-period cycle has run with dead time cutting both edges, and the prescaler has its division in effect. The bench restarts the generator for every configuration and waits two periods so the frame counter and dead-time age settle. It then sums drive-high clocks over exactly four periods and compares the result with a closed-form value. It sweeps every coarse value up to above the period, all fine values and several dead times at divides 1 and 2. A second sweep covers every prescaler code at a longer period. Configurations in which pulses merge across a period boundary are checked only for period length.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_START = 2'd1,
        PH_RUN   = 2'd2
    } run_ph_e;

endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
    parameter int SEL_W     = 3,
    parameter int MAX_SHIFT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } psc_st_t;

    psc_st_t    st_d, st_q;
    logic [SEL_W-1:0] shift;
    logic [CW:0]      lim_w;

    always_comb begin
        shift = (sel > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : sel;
        lim_w = ((CW+1)'(1) << shift) - (CW+1)'(1);
        tick  = !clr && ({1'b0, st_q.cnt} >= lim_w);
        st_d  = st_q;
        if (clr || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PSC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0)); // R1

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            raw_nx,
    input  logic [DT_W-1:0] dead,
    output logic            out_p,
    output logic            out_n
);
    typedef struct packed {
        logic            raw;
        logic [DT_W-1:0] age;
        logic            dp;
        logic            dn;
    } db_st_t;

    db_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else begin
            st_d.raw = raw_nx;
            if (raw_nx != st_q.raw) begin
                st_d.age = '0;
            end else if (tick && (st_q.age != '1)) begin
                st_d.age = st_q.age + DT_W'(1);
            end
            st_d.dp = raw_nx  && (st_d.age >= dead);
            st_d.dn = !raw_nx && (st_d.age >= dead);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_p = st_q.dp;
    assign out_n = st_q.dn;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_p && out_n)); // R6
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!out_p && !out_n)); // R8

endmodule

// File: rtl/cpwm_dt.sv
module cpwm_dt #(
    parameter int CNT_W     = 8,
    parameter int FINE_W    = 2,
    parameter int DT_W      = 4,
    parameter int SEL_W     = 3,
    parameter int MAX_SHIFT = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [CNT_W-1:0]        period_i,
    input  logic [CNT_W+FINE_W-1:0] duty_i,
    input  logic [SEL_W-1:0]        psc_sel_i,
    input  logic [DT_W-1:0]         dead_i,
    output logic                    out_p,
    output logic                    out_n,
    output logic                    period_end
);
    import cpwm_pkg::*;

    localparam int DUTY_W = CNT_W + FINE_W;

    typedef struct packed {
        logic              en;
        logic [CNT_W-1:0]  cnt;
        logic [FINE_W-1:0] frame;
        logic [CNT_W-1:0]  per;
        logic [DUTY_W-1:0] duty;
        logic              pe;
    } gen_st_t;

    gen_st_t          st_d, st_q;
    run_ph_e          ph;
    logic             tick;
    logic             wrap;
    logic             raw_nx;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] coarse_d;
    logic [FINE_W-1:0] fine_d;
    logic             stretch_d;
    logic [CNT_W:0]   thr_d;

    always_comb begin
        if (!en_i)          ph = PH_OFF;
        else if (!st_q.en)  ph = PH_START;
        else                ph = PH_RUN;
    end

    cpwm_prescaler #(
        .SEL_W    (SEL_W),
        .MAX_SHIFT(MAX_SHIFT)
    ) psc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ph != PH_RUN),
        .sel  (psc_sel_i),
        .tick (tick)
    );

    always_comb begin
        len_q = (st_q.per == '0) ? CNT_W'(1) : st_q.per;
        st_d    = st_q;
        st_d.pe = 1'b0;
        wrap    = 1'b0;
        unique case (ph)
            PH_OFF: begin
                st_d      = '0;
                st_d.per  = period_i;
                st_d.duty = duty_i;
            end
            PH_START: begin
                st_d.en    = 1'b1;
                st_d.cnt   = '0;
                st_d.frame = '0;
                st_d.per   = period_i;
                st_d.duty  = duty_i;
            end
            default: begin
                if (tick) begin
                    wrap = (st_q.cnt == len_q - CNT_W'(1));
                    if (wrap) begin
                        st_d.cnt   = '0;
                        st_d.frame = st_q.frame + FINE_W'(1);
                        st_d.per   = period_i;
                        st_d.duty  = duty_i;
                        st_d.pe    = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
        endcase
        coarse_d  = st_d.duty[DUTY_W-1:FINE_W];
        fine_d    = st_d.duty[FINE_W-1:0];
        stretch_d = (st_d.frame < fine_d);
        thr_d     = {1'b0, coarse_d} + (CNT_W+1)'(stretch_d);
        raw_nx    = (ph != PH_OFF) && ({1'b0, st_d.cnt} < thr_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cpwm_deadband #(
        .DT_W(DT_W)
    ) db_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ph != PH_OFF),
        .tick  (tick),
        .raw_nx(raw_nx),
        .dead  (dead_i),
        .out_p (out_p),
        .out_n (out_n)
    );

    assign period_end = st_q.pe;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |-> (st_q.cnt < len_q)); // R2
    AST_PE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> (st_q.cnt == '0)); // R9
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.en && !tick) |=> ($stable(st_q.per) && $stable(st_q.duty))); // R7
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && (st_q.duty == '0)) |-> !out_p); // R5
    AST_FULL_DUTY_NLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && (st_q.duty[DUTY_W-1:FINE_W] >= len_q)) |-> !out_n); // R5

endmodule

// File: tb/cpwm_dt_tb.sv
`timescale 1ns/1ps
module cpwm_dt_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [7:0] period_i = '0;
    logic [9:0] duty_i = '0;
    logic [2:0] psc_sel_i = '0;
    logic [3:0] dead_i = '0;
    logic       out_p, out_n, period_end;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cpwm_dt dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .period_i  (period_i),
        .duty_i    (duty_i),
        .psc_sel_i (psc_sel_i),
        .dead_i    (dead_i),
        .out_p     (out_p),
        .out_n     (out_n),
        .period_end(period_end)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int divof(input int ps);
        return 1 << ((ps > 6) ? 6 : ps);
    endfunction

    function automatic int pos(input int v);
        return (v > 0) ? v : 0;
    endfunction

    // Restart with a configuration, measure gaps and four-period drive sums.
    task automatic run_cfg(input int per, input int coarse, input int fine,
                           input int ps, input int dt);
        int len, dv, L, c, last, pe_n, hp, hn, ov, ep, en_x, h;
        bit full_all, mixed, do_n;
        en_i = 1'b0;
        period_i = 8'(per);
        duty_i = 10'(coarse * 4 + fine);
        psc_sel_i = 3'(ps);
        dead_i = 4'(dt);
        repeat (2) @(negedge clk);
        en_i = 1'b1;
        len = (per == 0) ? 1 : per;
        dv = divof(ps);
        L = len * dv;
        c = 0; last = 0; pe_n = 0; hp = 0; hn = 0; ov = 0;
        for (int i = 0; i < 7 * L + 8; i++) begin
            @(negedge clk);
            c++;
            if (out_p && out_n) ov++;
            if (period_end) begin
                pe_n++;
                if (pe_n == 1)
                    chk(c == L + 1, "R8 R1 first period length", c, L + 1);
                else
                    chk(c - last == L, "R1 R2 R9 period length", c - last, L);
                last = c;
            end
            if (pe_n >= 6) break;
            if (pe_n >= 2) begin
                if (out_p) hp++;
                if (out_n) hn++;
            end
        end
        chk(pe_n == 6, "R9 period markers seen", pe_n, 6);
        chk(ov == 0, "R6 drives overlap", ov, 0);
        full_all = (coarse >= len);
        mixed = !full_all && (fine > 0) && (coarse + 1 >= len);
        if (!mixed) begin
            if (full_all) ep = 4 * L;
            else begin
                ep = 0;
                for (int f = 0; f < 4; f++) begin
                    h = coarse + ((f < fine) ? 1 : 0);
                    ep += dv * pos(h - dt);
                end
            end
            if (full_all)
                chk(hp == ep, "R5 full duty true drive", hp, ep);
            else if (coarse == 0 && fine == 0)
                chk(hp == 0, "R5 zero duty true drive", hp, 0);
            else
                chk(hp == ep, "R3 R4 R6 true drive high", hp, ep);
            do_n = 1'b1;
            if (full_all) en_x = 0;
            else if (coarse == 0 && fine == 0) en_x = 4 * L;
            else if (coarse == 0) begin en_x = 0; do_n = 1'b0; end
            else begin
                en_x = 0;
                for (int f = 0; f < 4; f++) begin
                    h = coarse + ((f < fine) ? 1 : 0);
                    en_x += dv * pos(len - h - dt);
                end
            end
            if (do_n) begin
                if (full_all)
                    chk(hn == en_x, "R5 full duty inverted drive", hn, en_x);
                else
                    chk(hn == en_x, "R3 R4 R6 inverted drive high", hn, en_x);
            end
        end
    endtask

    initial begin
        int c, last, pe_n, hp;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!out_p && !out_n && !period_end, "R10 reset outputs", {out_p, out_n, period_end}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!out_p && !out_n && !period_end, "R8 disabled outputs", {out_p, out_n, period_end}, 0);

        // R2: period value zero acts as one tick
        run_cfg(0, 0, 0, 1, 0);

        // Sweep: coarse, fine, dead time at divide 1 and 2
        for (int ps = 0; ps < 2; ps++)
            for (int pi = 0; pi < 2; pi++)
                for (int co = 0; co <= ((pi == 0) ? 5 : 7); co++)
                    for (int fi = 0; fi < 4; fi++)
                        for (int dt = 0; dt < 4; dt++)
                            run_cfg((pi == 0) ? 4 : 6, co, fi, ps, dt);

        // R1: every prescaler code, including 7
        for (int ps = 0; ps < 8; ps++)
            run_cfg(5, 2, 1, ps, 1);

        // R7: a mid-period write waits for the next period
        en_i = 1'b0;
        period_i = 8'd6; duty_i = 10'd12; psc_sel_i = 3'd0; dead_i = 4'd0;
        repeat (2) @(negedge clk);
        en_i = 1'b1;
        c = 0; last = 0; pe_n = 0; hp = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            c++;
            if (period_end) begin
                pe_n++;
                if (pe_n == 3) chk(c - last == 6, "R7 current period keeps old length", c - last, 6);
                if (pe_n == 4) chk(c - last == 3, "R7 next period uses new length", c - last, 3);
                last = c;
                if (pe_n == 2) begin
                    repeat (2) @(negedge clk);
                    c += 2;
                    period_i = 8'd3; duty_i = 10'd4;
                end
            end
            if (pe_n == 3 && out_p) hp++;
            if (pe_n >= 4) break;
        end
        chk(hp == 1, "R7 new duty after period start", hp, 1);

        // R8: dropping enable clears the drives at once
        en_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!out_p && !out_n && !period_end, "R8 outputs low after disable",
                {out_p, out_n, period_end}, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule